// File: doc/BRIEF.md
# Sequential Write Burst Chainer

The block takes whole-line write transactions (64 bytes by default) one at a time and turns them into target-bus bursts. Each burst starts with one address phase. Data beats follow in ascending address order. When a newly arriving line begins exactly where the open burst currently ends, the block appends it to that burst without a second address phase. A line at a lower address, at the same address, or anywhere past the next line opens a new burst instead.

The final beat of each line is held back until the block knows whether that line ends the burst. Four events settle it. A following contiguous line keeps the burst open. A non-contiguous line closes it. A burst that reaches the configured maximum number of lines closes. A burst also closes when no write arrives within a programmable number of idle cycles. Only the beat that closes a burst carries the end marker. Both sides use valid/ready handshakes.

Top module: `wbc_burst_chainer`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1.
- R2: A write that opens a burst produces one address phase first (`out_is_addr`=1). Its `out_addr` is the write address with the low log2(LINE_BYTES) bits cleared. The line's beats follow in order: beat k carries `in_data[k*BEAT_W +: BEAT_W]`, and beat 0 is the least significant.
- R3: A write accepted while the burst waits is appended when its aligned address equals the burst start plus lines-so-far times LINE_BYTES, computed modulo 2^AW. The previous line's final beat is then sent with `out_last`=0, and the appended line's beats follow with no address phase.
- R4: A write accepted while the burst waits whose aligned address is not the continuing one closes the burst. This covers lower addresses. The previous final beat is sent with `out_last`=1, and then a new address phase is issued for the write.
- R5: A burst never holds more than MAX_LINES lines. Once it holds MAX_LINES, its final beat carries `out_last`=1, and the next write opens a new burst even when contiguous.
- R6: A waiting burst closes with `out_last`=1 after `idle_limit` consecutive waiting cycles without an accepted write. A value of 0 acts as 1. A write accepted in the cycle the limit would be reached is still appended.
- R7: `out_last` is 1 only on the final data beat of a burst and never during an address phase. After that beat the next output item is an address phase.
- R8: While `out_valid`=1 and `out_ready`=0, all output fields stay stable. `in_ready` and `out_valid` are never 1 together.
- R9: The low log2(LINE_BYTES) bits of `in_addr` are ignored both for the address phase and for the contiguity test.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| idle_limit | input | TW (8) | Idle cycles before a waiting burst closes |
| in_valid | input | 1 | Line write offered |
| in_ready | output | 1 | Line write accepted this cycle when valid |
| in_addr | input | AW (32) | Byte address of the line |
| in_data | input | LINE_BYTES*8 (512) | Line payload |
| out_valid | output | 1 | Output item present |
| out_ready | input | 1 | Target takes the item |
| out_is_addr | output | 1 | 1 marks an address phase, 0 marks a data beat |
| out_addr | output | AW (32) | Burst start address during address phase |
| out_data | output | BEAT_BYTES*8 (128) | Data beat payload |
| out_last | output | 1 | Final beat of the burst |

## Verification
A wrong burst length count or a wrong base address shows at the ports as soon as the next line arrives. The line is then appended when it should open a burst, or the other way round. That error becomes visible at the very next output item as a wrong `out_last` flag or an extra or missing address phase. A faulty idle counter moves the closing beat earlier or later than the idle count allows. Because the bench tracks the waiting period cycle by cycle, a line that arrives near the limit exposes the error within one burst. A wrong beat index or a held tail beat that is lost shows up immediately as mismatched beat data.

// File: rtl/wbc_pkg.sv
package wbc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ADDR = 3'd1,
    ST_BEAT = 3'd2,
    ST_HOLD = 3'd3,
    ST_TAIL = 3'd4
  } wbc_state_e;

  typedef enum logic [1:0] {
    TN_IDLE = 2'd0,
    TN_ADDR = 2'd1,
    TN_BEAT = 2'd2
  } wbc_tail_next_e;

endpackage

// File: rtl/wbc_idle_timer.sv
module wbc_idle_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          run,
  input  logic [TW-1:0] limit,
  output logic          expire
);

  logic [TW-1:0] cnt_q;
  logic [TW-1:0] lim_eff;

  // a zero limit behaves as a single waiting cycle
  function automatic logic [TW-1:0] effective_limit(input logic [TW-1:0] l);
    return (l == '0) ? TW'(1) : l;
  endfunction

  assign lim_eff = effective_limit(limit);
  assign expire  = run && (cnt_q == lim_eff - TW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      cnt_q <= '0;
    end else if (run && !expire) begin
      cnt_q <= cnt_q + TW'(1);
    end
  end

endmodule

// File: rtl/wbc_line_store.sv
module wbc_line_store #(
  parameter int BEAT_W = 128,
  parameter int NB     = 4,
  parameter int BIDX_W = 2,
  localparam int LINE_W = BEAT_W * NB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [LINE_W-1:0] line_in,
  input  logic [BIDX_W-1:0] beat_sel,
  input  logic              capture,
  output logic [BEAT_W-1:0] beat_out,
  output logic [BEAT_W-1:0] tail_out
);

  logic [LINE_W-1:0] line_q;
  logic [BEAT_W-1:0] tail_q;
  logic [BEAT_W-1:0] slices [NB];

  for (genvar g = 0; g < NB; g++) begin : g_slice
    assign slices[g] = line_q[g*BEAT_W +: BEAT_W];
  end

  assign beat_out = slices[beat_sel];
  assign tail_out = tail_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_q <= '0;
      tail_q <= '0;
    end else begin
      if (load)    line_q <= line_in;
      if (capture) tail_q <= slices[NB-1];
    end
  end

endmodule

// File: rtl/wbc_chain_ctrl.sv
module wbc_chain_ctrl
  import wbc_pkg::*;
#(
  parameter int AW         = 32,
  parameter int LINE_BYTES = 64,
  parameter int NB         = 4,
  parameter int MAX_LINES  = 4,
  parameter int BIDX_W     = 2,
  parameter int CNT_W      = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [AW-1:0]     in_addr,
  output logic              in_ready,
  output logic              accept,
  input  logic              out_ready,
  output logic              out_valid,
  output logic              out_is_addr,
  output logic [AW-1:0]     out_addr,
  output logic              out_last,
  output logic              show_tail,
  output logic [BIDX_W-1:0] beat_idx,
  output logic              in_hold,
  output logic              tmr_run,
  input  logic              tmr_expire,
  output logic              ev_chain,
  output logic              ev_break,
  output logic              ev_full,
  output logic              ev_timeout,
  output logic [CNT_W-1:0]  burst_lines
);

  localparam int LINE_SHIFT = $clog2(LINE_BYTES);
  localparam logic [AW-1:0] LINE_MASK = AW'(LINE_BYTES - 1);
  localparam bit SINGLE_BEAT = (NB == 1);
  localparam logic [BIDX_W-1:0] PRE_LAST = BIDX_W'((NB > 1) ? NB - 2 : 0);
  localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(MAX_LINES);

  wbc_state_e     st_q;
  wbc_tail_next_e tnext_q;
  logic [AW-1:0]     base_q;
  logic [CNT_W-1:0]  lines_q;
  logic [BIDX_W-1:0] bidx_q;
  logic              tlast_q;

  logic [AW-1:0] aligned;
  logic [AW-1:0] expect_addr;
  logic          contig;
  logic          full;
  logic          fire;
  logic          pre_last_fire;

  function automatic logic [AW-1:0] line_base(input logic [AW-1:0] a);
    return a & ~LINE_MASK;
  endfunction

  function automatic logic [AW-1:0] burst_end(input logic [AW-1:0] b,
                                              input logic [CNT_W-1:0] n);
    return b + (AW'(n) << LINE_SHIFT);
  endfunction

  assign aligned     = line_base(in_addr);
  assign expect_addr = burst_end(base_q, lines_q);
  assign contig      = (aligned == expect_addr);
  assign full        = (lines_q == MAX_CNT);
  assign in_hold     = (st_q == ST_HOLD);

  assign in_ready = (st_q == ST_IDLE) || (in_hold && !full);
  assign accept   = in_valid && in_ready;

  assign out_valid   = (st_q == ST_ADDR) || (st_q == ST_BEAT) || (st_q == ST_TAIL);
  assign out_is_addr = (st_q == ST_ADDR);
  assign out_addr    = base_q;
  assign show_tail   = (st_q == ST_TAIL);
  assign out_last    = show_tail && tlast_q;
  assign beat_idx    = bidx_q;
  assign burst_lines = lines_q;
  assign fire        = out_valid && out_ready;
  assign pre_last_fire = fire && (st_q == ST_BEAT) && (bidx_q == PRE_LAST);

  // decision events while the final beat of a line waits
  assign ev_full    = in_hold && full;
  assign ev_chain   = in_hold && accept && contig;
  assign ev_break   = in_hold && accept && !contig;
  assign tmr_run    = in_hold && !full && !accept;
  assign ev_timeout = tmr_run && tmr_expire;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      tnext_q <= TN_IDLE;
      base_q  <= '0;
      lines_q <= '0;
      bidx_q  <= '0;
      tlast_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (accept) begin
            base_q  <= aligned;
            lines_q <= CNT_W'(1);
            st_q    <= ST_ADDR;
          end
        end
        ST_ADDR: begin
          if (fire) begin
            bidx_q <= '0;
            st_q   <= SINGLE_BEAT ? ST_HOLD : ST_BEAT;
          end
        end
        ST_BEAT: begin
          if (pre_last_fire) begin
            st_q <= ST_HOLD;
          end else if (fire) begin
            bidx_q <= bidx_q + BIDX_W'(1);
          end
        end
        ST_HOLD: begin
          if (ev_full) begin
            tlast_q <= 1'b1;
            tnext_q <= TN_IDLE;
            st_q    <= ST_TAIL;
          end else if (ev_chain) begin
            lines_q <= lines_q + CNT_W'(1);
            tlast_q <= 1'b0;
            tnext_q <= TN_BEAT;
            st_q    <= ST_TAIL;
          end else if (ev_break) begin
            base_q  <= aligned;
            lines_q <= CNT_W'(1);
            tlast_q <= 1'b1;
            tnext_q <= TN_ADDR;
            st_q    <= ST_TAIL;
          end else if (ev_timeout) begin
            tlast_q <= 1'b1;
            tnext_q <= TN_IDLE;
            st_q    <= ST_TAIL;
          end
        end
        ST_TAIL: begin
          if (fire) begin
            bidx_q <= '0;
            unique case (tnext_q)
              TN_BEAT: st_q <= SINGLE_BEAT ? ST_HOLD : ST_BEAT;
              TN_ADDR: st_q <= ST_ADDR;
              default: st_q <= ST_IDLE;
            endcase
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/wbc_burst_chainer.sv
module wbc_burst_chainer #(
  parameter int AW         = 32,
  parameter int LINE_BYTES = 64,
  parameter int BEAT_BYTES = 16,
  parameter int MAX_LINES  = 4,
  parameter int TW         = 8,
  localparam int LINE_W    = LINE_BYTES * 8,
  localparam int BEAT_W    = BEAT_BYTES * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TW-1:0]     idle_limit,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [AW-1:0]     in_addr,
  input  logic [LINE_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_is_addr,
  output logic [AW-1:0]     out_addr,
  output logic [BEAT_W-1:0] out_data,
  output logic              out_last
);

  localparam int NB     = LINE_BYTES / BEAT_BYTES;
  localparam int BIDX_W = (NB > 1) ? $clog2(NB) : 1;
  localparam int CNT_W  = $clog2(MAX_LINES + 1);

  // named internal events, observed by the bound checker
  logic              accept;
  logic              show_tail;
  logic [BIDX_W-1:0] beat_idx;
  logic              in_hold;
  logic              tmr_run;
  logic              tmr_expire;
  logic              ev_chain;
  logic              ev_break;
  logic              ev_full;
  logic              ev_timeout;
  logic [CNT_W-1:0]  burst_lines;
  logic [BEAT_W-1:0] cur_beat;
  logic [BEAT_W-1:0] tail_beat;

  wbc_chain_ctrl #(
    .AW(AW), .LINE_BYTES(LINE_BYTES), .NB(NB), .MAX_LINES(MAX_LINES),
    .BIDX_W(BIDX_W), .CNT_W(CNT_W)
  ) ctrl_i (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_addr(in_addr), .in_ready(in_ready), .accept(accept),
    .out_ready(out_ready), .out_valid(out_valid), .out_is_addr(out_is_addr),
    .out_addr(out_addr), .out_last(out_last), .show_tail(show_tail),
    .beat_idx(beat_idx), .in_hold(in_hold), .tmr_run(tmr_run),
    .tmr_expire(tmr_expire), .ev_chain(ev_chain), .ev_break(ev_break),
    .ev_full(ev_full), .ev_timeout(ev_timeout), .burst_lines(burst_lines)
  );

  wbc_idle_timer #(.TW(TW)) timer_i (
    .clk(clk), .rst_n(rst_n), .clear(!in_hold), .run(tmr_run),
    .limit(idle_limit), .expire(tmr_expire)
  );

  wbc_line_store #(.BEAT_W(BEAT_W), .NB(NB), .BIDX_W(BIDX_W)) store_i (
    .clk(clk), .rst_n(rst_n), .load(accept), .line_in(in_data),
    .beat_sel(beat_idx), .capture(in_hold),
    .beat_out(cur_beat), .tail_out(tail_beat)
  );

  assign out_data = show_tail ? tail_beat : cur_beat;

endmodule

// File: rtl/wbc_burst_chainer_chk.sv
module wbc_burst_chainer_chk #(
  parameter int AW         = 32,
  parameter int LINE_BYTES = 64,
  parameter int BEAT_W     = 128,
  parameter int MAX_LINES  = 4,
  parameter int CNT_W      = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic              out_is_addr,
  input logic [AW-1:0]     out_addr,
  input logic [BEAT_W-1:0] out_data,
  input logic              out_last,
  input logic              ev_chain,
  input logic              ev_break,
  input logic              ev_full,
  input logic              ev_timeout,
  input logic [CNT_W-1:0]  burst_lines
);

  localparam logic [AW-1:0] LMASK = AW'(LINE_BYTES - 1);

  assert_addr_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_is_addr) |-> ((out_addr & LMASK) == '0));

  assert_chain_no_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_chain |=> (out_valid && !out_is_addr && !out_last));

  assert_break_closes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_break |=> (out_valid && out_last));

  assert_full_closes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_full |=> (out_valid && out_last));

  assert_lines_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    burst_lines <= CNT_W'(MAX_LINES));

  assert_timeout_closes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_timeout |=> (out_valid && out_last));

  assert_addr_not_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_is_addr) |-> !out_last);

  assert_after_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last) |=> (!out_valid || out_is_addr));

  assert_stall_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_is_addr) &&
      $stable(out_addr) && $stable(out_data) && $stable(out_last)));

  assert_in_out_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));

endmodule

bind wbc_burst_chainer wbc_burst_chainer_chk #(
  .AW(AW), .LINE_BYTES(LINE_BYTES), .BEAT_W(BEAT_W),
  .MAX_LINES(MAX_LINES), .CNT_W(CNT_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_is_addr(out_is_addr), .out_addr(out_addr),
  .out_data(out_data), .out_last(out_last), .ev_chain(ev_chain),
  .ev_break(ev_break), .ev_full(ev_full), .ev_timeout(ev_timeout),
  .burst_lines(burst_lines)
);

// File: tb/wbc_burst_chainer_tb.sv
module wbc_burst_chainer_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NB         = 4;
  localparam int MAXL       = 4;
  localparam int LB         = 64;

  typedef struct packed {
    logic         is_addr;
    logic [31:0]  addr;
    logic [127:0] data;
    logic         last;
    logic         hold_after;
    logic [7:0]   tag;
  } item_t;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [7:0]   idle_limit = 8'd6;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [31:0]  in_addr = '0;
  logic [511:0] in_data = '0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic         out_is_addr;
  logic [31:0]  out_addr;
  logic [127:0] out_data;
  logic         out_last;

  int  n_chk = 0;
  int  n_fail = 0;
  int  n_addr = 0;
  int  cyc = 0;
  bit  mon_on = 0;
  bit  rdy_rand = 0;
  bit  done = 0;
  logic [15:0] lfsr = 16'hACE1;

  // reference model state
  item_t        exp_q[$];
  bit           hold_m = 0;
  int           idle_m = 0;
  logic [31:0]  base_m = '0;
  int           lines_m = 0;
  logic [511:0] line_m = '0;
  bit           p_stall = 0;
  logic         p_isaddr, p_last;
  logic [31:0]  p_addr;
  logic [127:0] p_data;

  wbc_burst_chainer dut_i (
    .clk(clk), .rst_n(rst_n), .idle_limit(idle_limit),
    .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_is_addr(out_is_addr),
    .out_addr(out_addr), .out_data(out_data), .out_last(out_last)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input int req, input string what,
                     input logic [127:0] act, input logic [127:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL R%0d %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  function automatic logic [511:0] mk_line(input logic [31:0] seed);
    logic [511:0] d;
    for (int k = 0; k < 16; k++) d[k*32 +: 32] = seed * 32'h01000193 + 32'(k);
    return d;
  endfunction

  function automatic logic [127:0] beat_of(input logic [511:0] l, input int k);
    return l[k*128 +: 128];
  endfunction

  task automatic push_beats(input logic [511:0] l, input int tag);
    for (int k = 0; k < NB - 1; k++)
      exp_q.push_back('{1'b0, 32'h0, beat_of(l, k), 1'b0, (k == NB - 2), 8'(tag)});
  endtask

  task automatic push_tail(input bit last, input int tag);
    exp_q.push_back('{1'b0, 32'h0, beat_of(line_m, NB - 1), last, 1'b0, 8'(tag)});
  endtask

  task automatic open_burst(input logic [31:0] a, input logic [511:0] d, input int tag);
    base_m  = a & ~32'(LB - 1);
    lines_m = 1;
    line_m  = d;
    exp_q.push_back('{1'b1, base_m, 128'h0, 1'b0, 1'b0, 8'(tag)});
    push_beats(d, 2);
  endtask

  // cycle-by-cycle comparison, sampled at the falling edge
  always @(negedge clk) begin
    item_t f;
    bit start_hold;
    bit acc;
    logic [31:0] al;
    int lim;
    if (mon_on) begin
      start_hold = 0;
      acc = in_valid && in_ready;
      chk(!(in_ready && out_valid), 8, "in_ready with out_valid", {in_ready, out_valid}, 0);
      if (p_stall)
        chk(out_valid && out_is_addr == p_isaddr && out_addr == p_addr &&
            out_data == p_data && out_last == p_last, 8, "stall stability",
            out_data, p_data);
      if (hold_m)
        chk(!out_valid && in_ready, 3, "waiting: ready, no output",
            {out_valid, in_ready}, 2'b01);
      if (out_valid) begin
        if (exp_q.size() == 0) begin
          chk(0, 7, "unexpected output item", out_data, 0);
        end else begin
          f = exp_q[0];
          chk(out_is_addr == f.is_addr, f.tag, "item kind", out_is_addr, f.is_addr);
          if (f.is_addr) chk(out_addr == f.addr, f.tag, "address phase", out_addr, f.addr);
          else chk(out_data == f.data, f.tag, "beat data", out_data, f.data);
          chk(out_last == f.last, f.tag, "end marker (R7)", out_last, f.last);
          if (out_ready) begin
            void'(exp_q.pop_front());
            if (out_is_addr) n_addr++;
            start_hold = f.hold_after;
          end
        end
      end
      if (hold_m) begin
        if (acc) begin
          al = in_addr & ~32'(LB - 1);
          hold_m = 0;
          if (al == base_m + 32'(lines_m * LB)) begin
            push_tail(0, 3);
            lines_m++;
            line_m = in_data;
            push_beats(in_data, 3);
          end else begin
            push_tail(1, 4);
            open_burst(in_addr, in_data, 4);
          end
        end else begin
          idle_m++;
          lim = (idle_limit == 0) ? 1 : int'(idle_limit);
          if (idle_m >= lim) begin
            push_tail(1, 6);
            hold_m = 0;
          end
        end
      end else if (acc) begin
        open_burst(in_addr, in_data, 2);
      end
      if (start_hold) begin
        if (lines_m == MAXL) push_tail(1, 5);
        else begin
          hold_m = 1;
          idle_m = 0;
        end
      end
      p_stall  = out_valid && !out_ready;
      p_isaddr = out_is_addr;
      p_addr   = out_addr;
      p_data   = out_data;
      p_last   = out_last;
    end
  end

  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_ready = rdy_rand ? lfsr[0] : 1'b1;
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL R0 watchdog expired actual=%0d expected=%0d", cyc, 150000);
      finish_run();
    end
  end

  // call just after a rising edge; returns just after the accepting edge
  task automatic send(input logic [31:0] a);
    in_valid = 1'b1;
    in_addr  = a;
    in_data  = mk_line(a ^ 32'(cyc));
    do @(negedge clk); while (!in_ready);
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic gap(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic drain();
    int t = 0;
    do begin
      @(negedge clk);
      t++;
    end while ((exp_q.size() != 0 || hold_m || out_valid) && t < 5000);
    chk(t < 5000, 7, "drain completed", t, 0);
    @(posedge clk); #1;
  endtask

  task automatic expect_addr_phases(input int a0, input int want, input int req);
    chk(n_addr - a0 == want, req, "address phase count", n_addr - a0, want);
  endtask

  initial begin
    int a0;
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1 && out_valid == 1'b0, 1, "reset state",
        {in_ready, out_valid}, 2'b10);   // R1
    mon_on = 1;
    @(posedge clk); #1;

    // R3: three ascending lines chain into one burst
    a0 = n_addr;
    send(32'h1000); send(32'h1040); send(32'h1080);
    drain(); expect_addr_phases(a0, 1, 3);

    // R4: descending order splits
    a0 = n_addr;
    send(32'h2040); send(32'h2000);
    drain(); expect_addr_phases(a0, 2, 4);

    // R5: five contiguous lines exceed the maximum of four
    a0 = n_addr;
    for (int i = 0; i < 5; i++) send(32'h3000 + 32'(i * LB));
    drain(); expect_addr_phases(a0, 2, 5);

    // R9: unaligned offsets are dropped
    a0 = n_addr;
    send(32'h4013); send(32'h4055);
    drain(); expect_addr_phases(a0, 1, 9);

    // R6: long limit keeps the burst open across a gap
    idle_limit = 8'd200;
    a0 = n_addr;
    send(32'h5000); gap(20); send(32'h5040);
    drain(); expect_addr_phases(a0, 1, 6);
    // R6: short limit closes before the next write
    idle_limit = 8'd2;
    a0 = n_addr;
    send(32'h6000); gap(20); send(32'h6040);
    drain(); expect_addr_phases(a0, 2, 6);
    // R6: zero acts as one
    idle_limit = 8'd0;
    a0 = n_addr;
    send(32'h7000); gap(20); send(32'h7040);
    drain(); expect_addr_phases(a0, 2, 6);

    // R6: sweep gaps around the limit so arrival meets expiry
    idle_limit = 8'd3;
    for (int g = 0; g < 10; g++) begin
      send(32'hB000 + 32'(g * 32'h400));
      gap(g);
      send(32'hB040 + 32'(g * 32'h400));
      drain();
    end

    // R8: random backpressure with mixed ordering
    rdy_rand = 1;
    idle_limit = 8'd4;
    send(32'h8000); send(32'h8040); send(32'h9000); send(32'h8FC0);
    send(32'h9000); send(32'h9040); gap(3); send(32'h9080);
    for (int i = 0; i < 12; i++) begin
      send(32'hA000 + 32'(((i % 5) == 4) ? i * 3 * LB : i * LB));
      gap(i % 4);
    end
    drain();
    rdy_rand = 0;
    drain();

    // R2: wrap at the top of the address space stays contiguous
    a0 = n_addr;
    send(32'hFFFF_FFC0); send(32'h0000_0000);
    drain(); expect_addr_phases(a0, 1, 2);

    finish_run();
  end

endmodule